// File: doc/BRIEF.md
# Per-Channel Color Correction Lookup

The block corrects each pixel of an RGB video stream through three independent 256-entry by 8-bit tables, one per color channel. In wide mode each 8-bit component is used directly as the table address. In narrow mode only the six upper bits of each component are meaningful. They form the upper address bits, and a 2-bit level-select input supplies the two lower bits. Each table therefore holds four interleaved 64-entry correction curves, and the level select chooses one of them at run time. When correction is off, pixels go through unchanged.

Pixels enter and leave on valid/ready streams, with horizontal and vertical sync carried alongside the data. A transfer happens on any cycle where valid and ready are both high. The output stage holds its data, sync and valid steady while the downstream side withholds ready. The input is ready whenever the output stage is empty or is draining in that same cycle. A separate valid/ready write port loads the tables. Each table has a single port, so a table write has to yield to a pixel lookup while correction is enabled.

Top module: `chan_lut_corrector`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: When `lut_en` is 0 at acceptance, the output pixel and syncs equal the accepted input unchanged.
- R3: When `lut_en` is 1 and `mode18` is 0, each output component is that channel's table entry at the address equal to the input component. Red is `pix[23:16]`, green is `pix[15:8]` and blue is `pix[7:0]`.
- R4: When `lut_en` is 1 and `mode18` is 1, the address is {component[7:2], `lvl_sel`}. The output component is {entry[7:2], 2'b00}.
- R5: In narrow mode, `lvl_sel` values 0 to 3 select table addresses congruent to that value modulo 4. The same pixel read at different levels returns the entries of different curves.
- R6: A pixel accepted at a clock edge appears on `out_valid`/`out_pix` after that edge, exactly one cycle later, and its syncs appear with it.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output stays unchanged. `in_ready` equals `!out_valid || out_ready`.
- R8: While `lut_en` is 1, `wr_ready` is 0 in every cycle in which a pixel is accepted. While `lut_en` is 0, `wr_ready` is 1.
- R9: Reset leaves table contents unchanged.
- R10: A write with `wr_chan` 0, 1 or 2 changes only the red, green or blue table respectively. A write with `wr_chan` 3 is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| lut_en | input | 1 | Correction enable |
| mode18 | input | 1 | 1 selects narrow 6-bit mode, 0 selects wide 8-bit mode |
| lvl_sel | input | 2 | Curve select for narrow mode |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel ready |
| in_pix | input | 24 | Input pixel {R,G,B} |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel ready |
| out_pix | output | 24 | Corrected pixel {R,G,B} |
| out_hs | output | 1 | Horizontal sync aligned to `out_pix` |
| out_vs | output | 1 | Vertical sync aligned to `out_pix` |
| wr_valid | input | 1 | Table write request |
| wr_ready | output | 1 | Table write accepted |
| wr_chan | input | 2 | Target table: 0 red, 1 green, 2 blue, 3 none |
| wr_addr | input | 8 | Table address |
| wr_data | input | 8 | Table entry |

## Verification
The hardest situation to create is a table write that collides with a running corrected stream. The write must stay stalled for as long as pixels are accepted back to back. It must then land in the first gap, and the next lookups must see the new entry. The stimulus forks a continuous enabled stream and a write to an address that the following pixels read. Every cycle, the bench checks that the write is refused whenever a pixel handshake occurs. Back-pressure is exercised with an irregular `out_ready` pattern, and the output is compared across each stalled cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_SPARE = 2'd3
  } clut_chan_e;
endpackage

// File: rtl/clut_addr_gen.sv
module clut_addr_gen #(
  parameter int CW   = 8,
  parameter int LVLW = 2
) (
  input  logic [CW-1:0]   color,
  input  logic            mode18,
  input  logic [LVLW-1:0] lvl,
  output logic [CW-1:0]   addr
);
  always_comb begin
    if (mode18) addr = {color[CW-1:LVLW], lvl};
    else        addr = color;
  end
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [CW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rdata
);
  localparam int DEPTH = 1 << CW;

  logic [CW-1:0] mem [DEPTH];

  // single port: one access per cycle, write or read
  always_ff @(posedge clk) begin
    if (wr_en)      mem[wr_addr] <= wr_data;
    else if (rd_en) rdata <= mem[rd_addr];
  end

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst) !(wr_en && rd_en)); // R8
endmodule

// File: rtl/chan_lut_corrector.sv
module chan_lut_corrector #(
  parameter int CW   = 8,
  parameter int LVLW = 2,
  parameter int NCH  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lut_en,
  input  logic                mode18,
  input  logic [LVLW-1:0]     lvl_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NCH*CW-1:0]   in_pix,
  input  logic                in_hs,
  input  logic                in_vs,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NCH*CW-1:0]   out_pix,
  output logic                out_hs,
  output logic                out_vs,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [1:0]          wr_chan,
  input  logic [CW-1:0]       wr_addr,
  input  logic [CW-1:0]       wr_data
);
  import clut_pkg::*;

  localparam int PW = NCH * CW;

  logic          adv;
  logic          wr_fire;
  logic          en_q, m18_q;
  logic          hs_q, vs_q;
  logic [PW-1:0] pass_q;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;
  assign wr_ready = !(lut_en && adv);
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      pass_q <= in_pix;
      hs_q   <= in_hs;
      vs_q   <= in_vs;
      en_q   <= lut_en;
      m18_q  <= mode18;
    end
  end

  assign out_hs = hs_q;
  assign out_vs = vs_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam clut_chan_e MY_CH = clut_chan_e'(c);
    localparam int LSB = (NCH - 1 - c) * CW;

    logic [CW-1:0] rd_addr;
    logic [CW-1:0] rdata;
    logic [CW-1:0] corr;

    clut_addr_gen #(.CW(CW), .LVLW(LVLW)) u_addr (
      .color  (in_pix[LSB +: CW]),
      .mode18 (mode18),
      .lvl    (lvl_sel),
      .addr   (rd_addr)
    );

    clut_bank #(.CW(CW)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .rd_en   (adv && lut_en),
      .rd_addr (rd_addr),
      .wr_en   (wr_fire && (wr_chan == MY_CH)),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rdata   (rdata)
    );

    always_comb begin
      if (m18_q) corr = {rdata[CW-1:LVLW], {LVLW{1'b0}}};
      else       corr = rdata;
    end

    assign out_pix[LSB +: CW] = en_q ? corr : pass_q[LSB +: CW];
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_hs) && $stable(out_vs)); // R7
  AST_READY_FREE: assert property (@(posedge clk) disable iff (rst) !out_valid |-> in_ready); // R7
  AST_LAT_ONE: assert property (@(posedge clk) disable iff (rst) adv |=> out_valid); // R6
  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    adv |=> (out_hs == $past(in_hs)) && (out_vs == $past(in_vs))); // R6
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    adv && !lut_en |=> out_pix == $past(in_pix)); // R2
endmodule

// File: tb/chan_lut_corrector_test.sv
module chan_lut_corrector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lut_en = 1'b0, mode18 = 1'b0;
  logic [1:0]  lvl_sel = 2'd0;
  logic        in_valid = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [23:0] in_pix = '0;
  logic        out_ready = 1'b1;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_chan = 2'd0;
  logic [7:0]  wr_addr = '0, wr_data = '0;
  logic        in_ready, out_valid, out_hs, out_vs, wr_ready;
  logic [23:0] out_pix;

  int vectors = 0, fails = 0;
  logic [7:0]  tbl [3][256];
  logic [25:0] expq [$];
  string       tagq [$];
  bit          stall_mode = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  chan_lut_corrector uut (
    .clk(clk), .rst(rst), .lut_en(lut_en), .mode18(mode18), .lvl_sel(lvl_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_hs(in_hs), .in_vs(in_vs),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_hs(out_hs), .out_vs(out_vs),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] corr(input int ch, input logic [7:0] v);
    logic [7:0] a;
    if (!lut_en) return v;
    if (mode18) begin
      a = {v[7:2], lvl_sel};
      return {tbl[ch][a][7:2], 2'b00};
    end
    return tbl[ch][v];
  endfunction

  task automatic send(input logic [7:0] r, g, b, input logic hs, vs, input string tag);
    bit hsk;
    in_valid = 1'b1; in_pix = {r, g, b}; in_hs = hs; in_vs = vs;
    forever begin
      @(negedge clk);
      hsk = in_ready;
      if (hsk) begin
        expq.push_back({hs, vs, corr(0, r), corr(1, g), corr(2, b)});
        tagq.push_back(tag);
      end
      @(posedge clk); #1;
      if (hsk) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic twrite(input logic [1:0] ch, input logic [7:0] a, d);
    bit hsk;
    wr_valid = 1'b1; wr_chan = ch; wr_addr = a; wr_data = d;
    forever begin
      @(negedge clk);
      hsk = wr_ready;
      if (hsk && ch != 2'd3) tbl[ch][a] = d;
      @(posedge clk); #1;
      if (hsk) break;
    end
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  // monitor / scoreboard
  logic        prev_stall = 0;
  logic [25:0] prev_out = '0;
  initial forever begin
    @(negedge clk);
    if (rst) prev_stall = 0;
    else begin
      if (prev_stall)
        check(out_valid && {out_hs, out_vs, out_pix} == prev_out, "R7 stall hold",
              {6'd0, out_hs, out_vs, out_pix}, {6'd0, prev_out});
      check(in_ready == (!out_valid || out_ready), "R7 in_ready rule", in_ready, !out_valid || out_ready);
      if (lut_en && in_valid && in_ready)
        check(!wr_ready, "R8 write yields to pixel", wr_ready, 0);
      if (!lut_en) check(wr_ready, "R8 write free when off", wr_ready, 1);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(0, "R6 unexpected output", out_pix, 0);
        else begin
          logic [25:0] e;
          string t;
          e = expq.pop_front(); t = tagq.pop_front();
          check({out_hs, out_vs, out_pix} == e, t, {6'd0, out_hs, out_vs, out_pix}, {6'd0, e});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_hs, out_vs, out_pix};
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (stall_mode) out_ready = ($urandom % 3) != 0;
  end

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 reset state", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1;

    // load all tables while correction is off (R8: never refused)
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 256; a++)
        twrite(2'(c), 8'(a), 8'((a * 7 + c * 61 + 13) & 255));

    // R2 pass-through with sync patterns
    for (int i = 0; i < 8; i++)
      send(8'(i * 33), 8'(255 - i), 8'(i * 3 + 1), i[0], i[1], "R2 pass-through");
    drain();

    // R3 wide mode
    lut_en = 1'b1;
    send(8'h00, 8'hFF, 8'h80, 1, 0, "R3 wide corners");
    send(8'hFF, 8'h00, 8'h01, 0, 1, "R3 wide corners");
    for (int i = 0; i < 10; i++)
      send(8'(i * 25), 8'(i * 17 + 3), 8'(200 - i * 9), 0, 0, "R3 wide lookup");
    drain();

    // R6 latency
    send(8'h12, 8'h34, 8'h56, 1, 1, "R6 latency data");
    check(out_valid, "R6 valid one cycle later", out_valid, 1);
    drain();

    // R4 / R5 narrow mode, every level
    mode18 = 1'b1;
    for (int l = 0; l < 4; l++) begin
      lvl_sel = 2'(l);
      send(8'hFC, 8'h00, 8'h84, 0, 0, "R5 level curve");
      for (int i = 0; i < 4; i++)
        send(8'(i * 64 + 8), 8'(i * 40 + 4), 8'(i * 12), 1, 0, "R4 narrow lookup");
      drain();
    end
    mode18 = 1'b0; lvl_sel = 2'd0;

    // R7 back-pressure
    stall_mode = 1;
    for (int i = 0; i < 40; i++)
      send(8'(i * 5), 8'(i * 11), 8'(i * 13), i[0], i[2], "R7 back-pressure");
    drain();
    stall_mode = 0; out_ready = 1'b1;
    drain();

    // R8 collision: write starved by back-to-back stream, then visible
    fork
      for (int i = 0; i < 20; i++) send(8'h40, 8'h41, 8'h42, 0, 0, "R8 stream during write");
      begin @(posedge clk); #1; twrite(2'd1, 8'h41, 8'hA5); end
    join
    drain();
    // R10 only green changed
    send(8'h41, 8'h41, 8'h41, 0, 0, "R10 channel isolation");
    twrite(2'd3, 8'h41, 8'h00);
    send(8'h41, 8'h41, 8'h41, 0, 0, "R10 spare channel ignored");
    drain();

    // R9 tables survive reset
    rst = 1'b1; @(posedge clk); @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 state after reset", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++)
      send(8'(i * 41), 8'h41, 8'(i * 7), 0, 1, "R9 retained after reset");
    drain();

    done = 1;
    report();
  end
endmodule